// File: doc/BRIEF.md
# Two-Owner SMBus Ownership Semaphore

This block decides who may drive a shared SMBus controller: the host CPU or an embedded microcontroller that also uses the bus, for example for fan and temperature monitoring. It holds one of three states. FREE means nobody owns the bus. HOST_OWN means the host has been granted ownership. EC_OWN means the embedded controller has been granted ownership.

The host works through one control register. Writing 1 to the request bit asks for ownership. The host then reads the same bit back: 1 means the request was granted, and 0 means the embedded controller still holds the bus. Writing 1 to a separate release bit frees the bus. That release bit clears itself and always reads 0.

The host's software polls the request bit and gives up after a bounded number of tries. A denied request therefore leaves nothing pending. The embedded controller has its own request and release inputs and its own grant output. The host's start strobe toward the bus engine passes only while the host holds the grant.

The state transitions are as follows:
- FREE to EC_OWN on an embedded-controller request. This takes priority over a host request in the same cycle.
- FREE to HOST_OWN on a host request write.
- HOST_OWN to FREE on a host release write.
- EC_OWN to FREE on an embedded-controller release.
- Every other input combination holds the current state.

Top module: `smbus_own_sema`

## Requirements
- R1: After reset the state is FREE: `host_grant` and `ec_grant` are 0 and `csr_rdata` is 8'h00.
- R2: In FREE with `ec_req` low, a write (`csr_wr`=1) with `csr_wdata[4]`=1 moves to HOST_OWN. From the next cycle `host_grant` is 1 and `csr_rdata[4]` reads 1.
- R3: In HOST_OWN, a write with `csr_wdata[5]`=1 returns to FREE in the next cycle, whatever the value of bit 4. `csr_rdata[5]` reads 0 in every state.
- R4: In FREE, `ec_req`=1 moves to EC_OWN in the next cycle (`ec_grant`=1). EC_OWN holds until `ec_rel`=1. While in EC_OWN, host writes have no effect and `csr_rdata[4]` reads 0.
- R5: A host request denied during EC_OWN leaves no pending state. After the embedded controller releases, the state is FREE (`host_grant`=0) until the host writes bit 4 again.
- R6: When `ec_req`=1 and a host request write arrive in the same cycle in FREE, the embedded controller wins: next `ec_grant`=1 and `host_grant`=0.
- R7: `bus_start` equals `host_start` in a cycle where the state is HOST_OWN, and is 0 otherwise. The path is combinational, so `bus_start` follows `host_start` in the same cycle.
- R8: In HOST_OWN, `ec_req` and `ec_rel` are ignored: `ec_grant` stays 0 and the host keeps ownership.
- R9: These writes cause no state change:
  - any write with bits 4 and 5 both 0;
  - a bit-5 write in FREE;
  - a bit-4 write in HOST_OWN.
- R10: Every `csr_rdata` bit other than bit 4 reads 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Host write strobe for the control register |
| csr_wdata | input | 8 | Host write data; bit 4 is request, bit 5 is release |
| csr_rdata | output | 8 | Control register readback; bit 4 is 1 while the host owns |
| ec_req | input | 1 | Embedded controller ownership request |
| ec_rel | input | 1 | Embedded controller release |
| ec_grant | output | 1 | Embedded controller holds ownership |
| host_grant | output | 1 | Host holds ownership |
| host_start | input | 1 | Host start strobe toward the bus engine |
| bus_start | output | 1 | Gated start strobe |

## Verification
A wrong state shows up at the ports in the cycle after the offending input.

A lost or extra transition changes `host_grant`, `ec_grant` and `csr_rdata[4]` one clock after the write or controller pulse. A wrong gate shows in the same cycle, because `bus_start` follows `host_start` combinationally.

A request that is wrongly remembered stays hidden while EC_OWN holds. It surfaces only one cycle after `ec_rel`, as an unexpected host grant. The bench therefore drives every input combination from each of the three states and checks the cycle right after each release.

// File: rtl/sema_pkg.sv
package sema_pkg;
    typedef enum logic [1:0] {
        SEM_FREE = 2'd0,
        SEM_HOST = 2'd1,
        SEM_EC   = 2'd2
    } sem_state_t;
endpackage

// File: rtl/sema_csr_decode.sv
module sema_csr_decode #(
    parameter int CSR_W   = 8,
    parameter int REQ_BIT = 4,
    parameter int REL_BIT = 5
) (
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    output logic             host_req,
    output logic             host_rel
);
    // Remaining data bits carry no meaning for the semaphore.
    logic wdata_unused;

    assign host_req     = wr && wdata[REQ_BIT];
    assign host_rel     = wr && wdata[REL_BIT];
    assign wdata_unused = ^wdata;
endmodule

// File: rtl/sema_arbiter.sv
module sema_arbiter
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic host_rel,
    input  logic ec_req,
    input  logic ec_rel,
    output logic host_own,
    output logic ec_own
);
    sem_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEM_FREE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEM_FREE: begin
                // Controller wins a same-cycle tie.
                if (ec_req)        state_nxt = SEM_EC;
                else if (host_req) state_nxt = SEM_HOST;
            end
            SEM_HOST: begin
                // Release overrides a simultaneous request bit.
                if (host_rel) state_nxt = SEM_FREE;
            end
            SEM_EC: begin
                if (ec_rel) state_nxt = SEM_FREE;
            end
            default: state_nxt = SEM_FREE;
        endcase
    end

    always_comb begin
        host_own = 1'b0;
        ec_own   = 1'b0;
        unique case (state)
            SEM_FREE: ;
            SEM_HOST: host_own = 1'b1;
            SEM_EC:   ec_own   = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sema_view.sv
module sema_view #(
    parameter int CSR_W   = 8,
    parameter int REQ_BIT = 4
) (
    input  logic             host_own,
    input  logic             host_start,
    output logic [CSR_W-1:0] rdata,
    output logic             bus_start
);
    for (genvar i = 0; i < CSR_W; i++) begin : g_rd
        if (i == REQ_BIT) begin : g_req
            assign rdata[i] = host_own;
        end else begin : g_zero
            assign rdata[i] = 1'b0;
        end
    end

    assign bus_start = host_start && host_own;
endmodule

// File: rtl/smbus_own_sema.sv
module smbus_own_sema #(
    parameter int CSR_W   = 8,
    parameter int REQ_BIT = 4,
    parameter int REL_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             ec_req,
    input  logic             ec_rel,
    output logic             ec_grant,
    output logic             host_grant,
    input  logic             host_start,
    output logic             bus_start
);
    logic host_req, host_rel;

    sema_csr_decode #(.CSR_W(CSR_W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) u_dec (
        .wr(csr_wr), .wdata(csr_wdata), .host_req(host_req), .host_rel(host_rel)
    );

    sema_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_rel(host_rel),
        .ec_req(ec_req), .ec_rel(ec_rel), .host_own(host_grant), .ec_own(ec_grant)
    );

    sema_view #(.CSR_W(CSR_W), .REQ_BIT(REQ_BIT)) u_view (
        .host_own(host_grant), .host_start(host_start),
        .rdata(csr_rdata), .bus_start(bus_start)
    );
endmodule

// File: rtl/sema_checker.sv
module sema_checker #(
    parameter int CSR_W   = 8,
    parameter int REQ_BIT = 4,
    parameter int REL_BIT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr,
    input logic [CSR_W-1:0] csr_wdata,
    input logic [CSR_W-1:0] csr_rdata,
    input logic             ec_req,
    input logic             ec_rel,
    input logic             ec_grant,
    input logic             host_grant,
    input logic             host_start,
    input logic             bus_start
);
    AST_HOST_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_grant && !ec_grant && !ec_req && csr_wr && csr_wdata[REQ_BIT]) |=> host_grant); // R2
    AST_RD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[REQ_BIT] == host_grant); // R2
    AST_HOST_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant && csr_wr && csr_wdata[REL_BIT]) |=> !host_grant); // R3
    AST_EC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ec_grant && !ec_rel) |=> (ec_grant && !host_grant)); // R4
    AST_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_grant) |-> $past(csr_wr && csr_wdata[REQ_BIT] && !ec_grant)); // R5
    AST_TIE_EC: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_grant && !ec_grant && ec_req && csr_wr && csr_wdata[REQ_BIT]) |=> (ec_grant && !host_grant)); // R6
    AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_start && !host_grant) |-> !bus_start); // R7
    AST_HOST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant && !(csr_wr && csr_wdata[REL_BIT])) |=> (host_grant && !ec_grant)); // R8
endmodule

bind smbus_own_sema sema_checker #(.CSR_W(CSR_W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ec_req(ec_req), .ec_rel(ec_rel), .ec_grant(ec_grant), .host_grant(host_grant),
    .host_start(host_start), .bus_start(bus_start)
);

// File: tb/sim_smbus_own_sema.sv
module sim_smbus_own_sema;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] csr_rdata;
    logic       ec_req = 1'b0, ec_rel = 1'b0, host_start = 1'b0;
    logic       ec_grant, host_grant, bus_start;

    int compared = 0;
    int mismatched = 0;
    int mstate = 0; // 0 free, 1 host, 2 controller

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_own_sema u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .ec_req(ec_req), .ec_rel(ec_rel), .ec_grant(ec_grant), .host_grant(host_grant),
        .host_start(host_start), .bus_start(bus_start)
    );

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        check(tag, int'(host_grant), int'(mstate == 1));
        check(tag, int'(ec_grant), int'(mstate == 2));
        check(tag, int'(csr_rdata[4]), int'(mstate == 1));
        check("R3", int'(csr_rdata[5]), 0);
        check("R10", int'(csr_rdata & 8'hEF), 0);
    endtask

    function automatic int model_next(int s, logic wr, logic b4, logic b5, logic er, logic el);
        if (s == 0) return er ? 2 : ((wr && b4) ? 1 : 0);
        if (s == 1) return (wr && b5) ? 0 : 1;
        return el ? 0 : 2;
    endfunction

    task automatic step(input logic wr, input logic [7:0] wd, input logic er,
                        input logic el, input logic st, input string tag);
        int nxt;
        @(negedge clk);
        csr_wr = wr; csr_wdata = wd; ec_req = er; ec_rel = el; host_start = st;
        #1;
        check("R7", int'(bus_start), int'(st && mstate == 1));
        nxt = model_next(mstate, wr, wd[4], wd[5], er, el);
        @(negedge clk);
        mstate = nxt;
        check_outputs(tag);
        csr_wr = 1'b0; csr_wdata = 8'h00; ec_req = 1'b0; ec_rel = 1'b0; host_start = 1'b0;
    endtask

    task automatic go_to(input int s);
        step(1'b1, 8'h20, 1'b0, 1'b1, 1'b0, "R3");
        if (s == 1) step(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, "R2");
        if (s == 2) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R4");
    endtask

    function automatic string pick_tag(int s, logic wr, logic b4, logic b5, logic er, logic el);
        if (s == 0 && er && wr && b4) return "R6";
        if (s == 0 && er) return "R4";
        if (s == 0 && wr && b4) return "R2";
        if (s == 1 && wr && b5) return "R3";
        if (s == 1 && (er || el)) return "R8";
        if (s == 2) return "R4";
        return "R9";
    endfunction

    initial begin
        repeat (40000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        mstate = 0;
        check_outputs("R1");
        check("R1", int'(csr_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");

        // Near-exhaustive sweep: each state x each input combination.
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 64; c++) begin
                logic wr, b4, b5, er, el, st;
                logic [7:0] wd;
                wr = c[0]; b4 = c[1]; b5 = c[2]; er = c[3]; el = c[4]; st = c[5];
                wd = (8'((c * 37) + s) & 8'hCF) | {2'b00, b5, b4, 4'h0};
                go_to(s);
                step(wr, wd, er, el, st, pick_tag(s, wr, b4, b5, er, el));
                // Start strobe observed in the resulting state as well.
                step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R7");
            end
        end

        // R5: denied request leaves nothing pending after the controller releases.
        go_to(2);
        step(1'b1, 8'h10, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R5");
        check("R5", int'(host_grant), 0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R5");
        step(1'b1, 8'h10, 1'b0, 1'b0, 1'b1, "R5");
        check("R5", int'(host_grant), 1);

        // R9: write with request and release both 0 while free.
        go_to(0);
        step(1'b1, 8'hCF, 1'b0, 1'b0, 1'b0, "R9");
        check("R9", int'(host_grant), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule